// File: doc/BRIEF.md
# Burst Address Generator

This block sits in front of a synchronous memory array and turns one captured word address into the address sequence of a four-beat burst. An access begins when the three chip enables are all in their active state and at least one of two active-low address strobes (one driven by a processor, one by a cache controller) is low. On that clock edge the full address is registered. The two low bits become the burst start, and the upper bits stay fixed for the whole burst.

Each later edge with the active-low advance input low and no new load moves to the next beat. With advance high, the current address is held and the burst is suspended. The beat order is chosen by a mode input. With mode high the order is interleaved: the start bits XOR a beat count. With mode low the order is linear: the start bits plus the beat count, modulo four. Both orders wrap after the fourth beat.

A small state machine tracks whether a burst has been loaded since reset. It has two states. In ST_IDLE no burst is loaded and advance is ignored. In ST_BURST a burst is loaded. The named transitions are T_LOAD (ST_IDLE to ST_BURST on a load), T_RELOAD (a load in ST_BURST), T_STEP (an advance in ST_BURST), T_HOLD (no load and no advance in ST_BURST) and T_WAIT (no load in ST_IDLE). Synchronous reset returns the machine to ST_IDLE.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high on a clock edge, the next outputs are `addr_out` = 0 and `burst_loaded` = 0, whatever the other inputs are.
- R2: A load happens on an edge when `ce1_n`=0, `ce2`=1, `ce3_n`=0 and `ads_p_n` or `ads_c_n` is 0. After that edge `addr_out` equals the sampled `addr_in` and `burst_loaded` is 1. Once set, `burst_loaded` stays 1 until reset.
- R3: With `ce2`=0 or `ce3_n`=1, a low controller strobe loads nothing: `addr_out` and `burst_loaded` are unchanged.
- R4: While `ce1_n`=1, neither strobe loads an address. In particular a low processor strobe loads nothing.
- R5: When both strobes are low together with the chips enabled, exactly one load of `addr_in` takes place, on behalf of the processor strobe. The beat restarts at the start address.
- R6: Between loads, `addr_out[15:2]` does not change, whatever happens on advance or mode.
- R7: With `mode`=1 (interleaved), beat k (0 to 3) outputs low bits = start XOR k. For example, start 01 gives 01, 00, 11, 10.
- R8: With `mode`=0 (linear), beat k outputs low bits = (start + k) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R9: An edge with `adv_n`=1 and no load leaves `addr_out` unchanged (suspended burst).
- R10: After four advances the low bits return to the start value, and the sequence repeats.
- R11: A load on the same edge as `adv_n`=0 takes priority. The new address appears with the beat count back at zero.
- R12: Before the first load after reset, `adv_n`=0 has no effect: `addr_out` stays 0 and `burst_loaded` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | 16 | Word address sampled on a load |
| ads_p_n | input | 1 | Processor address strobe, active low, gated by ce1_n |
| ads_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr_out | output | 16 | Current array address |
| burst_loaded | output | 1 | High once a burst has been loaded since reset |

## Verification
The assertions assume that every input is a clean 0 or 1 at each rising edge, and that reset is applied before any other traffic. The order-step assertions only count an advance while `mode` holds steady across it; a change of mode mid-burst excuses the check rather than being judged. The stimulus follows these assumptions. It drives every input one nanosecond after a rising edge, starts with reset high, and changes `mode` only between bursts, never across an advance being checked.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Burst tracking states
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_e;

    // Beat ordering selected by the mode input
    typedef enum logic [0:0] {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/strobe_arbiter.sv
// Decides whether this edge loads a new burst address.
// The processor strobe wins over the controller strobe; both load the same
// address, so the winner only matters for gating: the processor strobe is
// honoured solely while ce1_n is low.
module strobe_arbiter (
    input  logic ads_p_n,
    input  logic ads_c_n,
    input  logic ce1_n,
    input  logic ce2,
    input  logic ce3_n,
    output logic load
);
    logic chip_sel;
    logic proc_req;
    logic ctrl_req;

    always_comb begin
        chip_sel = !ce1_n && ce2 && !ce3_n;
        proc_req = !ads_p_n && !ce1_n;
        // controller request is only considered when the processor is silent
        ctrl_req = !ads_c_n && !proc_req;
        load     = chip_sel && (proc_req || ctrl_req);
    end
endmodule

// File: rtl/beat_order.sv
// Maps start bits and beat count onto the low address bits.
module beat_order #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              mode,
    output logic [BEAT_W-1:0] low
);
    import burst_addr_pkg::*;

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    genvar gi;
    generate
        for (gi = 0; gi < BEAT_W; gi++) begin : g_xor_bit
            assign ilv_low[gi] = start[gi] ^ beat[gi];
        end
    endgenerate

    assign lin_low = start + beat;

    always_comb begin
        unique case (burst_order_e'(mode))
            ORD_INTERLEAVE: low = ilv_low;
            ORD_LINEAR:     low = lin_low;
            default:        low = lin_low;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ads_p_n,
    input  logic              ads_c_n,
    input  logic              adv_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              mode,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_loaded
);
    import burst_addr_pkg::*;

    localparam int UPPER_W = ADDR_W - BEAT_W;

    burst_state_e      state_q;
    burst_state_e      state_d;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic              load;
    logic              step;
    logic [BEAT_W-1:0] low_bits;

    strobe_arbiter u_arb (
        .ads_p_n (ads_p_n),
        .ads_c_n (ads_c_n),
        .ce1_n   (ce1_n),
        .ce2     (ce2),
        .ce3_n   (ce3_n),
        .load    (load)
    );

    // Next state: T_LOAD / T_WAIT from idle, T_RELOAD / T_STEP / T_HOLD in burst
    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load) state_d = ST_BURST;
            end
            ST_BURST: begin
                state_d = ST_BURST;
                step    = !load && !adv_n;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and burst registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                base_q <= addr_in;
                beat_q <= '0;
            end else if (step) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    beat_order #(.BEAT_W(BEAT_W)) u_order (
        .start (base_q[BEAT_W-1:0]),
        .beat  (beat_q),
        .mode  (mode),
        .low   (low_bits)
    );

    // Outputs
    always_comb begin
        burst_loaded = (state_q == ST_BURST);
        addr_out     = {base_q[ADDR_W-1 -: UPPER_W], low_bits};
    end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              ads_p_n,
    input logic              ads_c_n,
    input logic              adv_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              mode,
    input logic [ADDR_W-1:0] addr_out,
    input logic              burst_loaded
);
    logic ld;
    assign ld = (!ce1_n && ce2 && !ce3_n) && (!ads_p_n || !ads_c_n);

    // R2: a qualified strobe captures the address and flags the burst
    p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
        ld |=> (burst_loaded && addr_out == $past(addr_in)));

    // R2: the loaded flag stays set until reset
    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        burst_loaded |=> burst_loaded);

    // R12: nothing moves before the first load
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (!ld && !burst_loaded) |=> (!burst_loaded && addr_out == $past(addr_out)));

    // R6: upper bits fixed between loads
    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        !ld |=> (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));

    // R9: suspended burst holds its address while mode is steady
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ld && adv_n) |=> ((mode != $past(mode)) || addr_out == $past(addr_out)));

    // R8: linear order steps the low bits by one
    p_linear_step_r8: assert property (@(posedge clk) disable iff (rst)
        (!ld && !adv_n && burst_loaded && !mode) |=>
            (mode || addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
    localparam int CLK_HALF = 2;
    localparam int WD_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr_in;
    logic        ads_p_n, ads_c_n, adv_n, ce1_n, ce2, ce3_n, mode;
    logic [15:0] addr_out;
    logic        burst_loaded;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model of the requirements
    logic [15:0] e_base;
    logic [1:0]  e_beat;
    logic        e_loaded;

    always #(CLK_HALF) clk = ~clk;

    burst_addr_gen u_burst_addr_gen (
        .clk          (clk),
        .rst          (rst),
        .addr_in      (addr_in),
        .ads_p_n      (ads_p_n),
        .ads_c_n      (ads_c_n),
        .adv_n        (adv_n),
        .ce1_n        (ce1_n),
        .ce2          (ce2),
        .ce3_n        (ce3_n),
        .mode         (mode),
        .addr_out     (addr_out),
        .burst_loaded (burst_loaded)
    );

    function automatic logic [15:0] exp_addr();
        logic [1:0] lo;
        lo = mode ? (e_base[1:0] ^ e_beat) : 2'(e_base[1:0] + e_beat);
        return {e_base[15:2], lo};
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Advance the model with the inputs present at the coming edge,
    // wait past the edge, then compare.
    task automatic step(input string tag);
        logic ld;
        ld = !ce1_n && ce2 && !ce3_n && (!ads_p_n || !ads_c_n);
        if (rst) begin
            e_base = '0; e_beat = '0; e_loaded = 1'b0;
        end else if (ld) begin
            e_base = addr_in; e_beat = '0; e_loaded = 1'b1;
        end else if (e_loaded && !adv_n) begin
            e_beat = e_beat + 2'd1;
        end
        @(posedge clk);
        #1;
        n_chk++;
        if (addr_out !== exp_addr() || burst_loaded !== e_loaded) begin
            n_fail++;
            $display("FAIL %s: addr_out=%h burst_loaded=%b expected addr_out=%h burst_loaded=%b",
                     tag, addr_out, burst_loaded, exp_addr(), e_loaded);
        end
    endtask

    task automatic quiet();
        ads_p_n = 1; ads_c_n = 1; adv_n = 1;
        ce1_n = 0; ce2 = 1; ce3_n = 0;
    endtask

    initial begin
        #(WD_CYCLES * 2 * CLK_HALF);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        e_base = '0; e_beat = '0; e_loaded = 0;
        rst = 1; mode = 0; addr_in = 16'hBEEF;
        quiet();
        ads_c_n = 0; adv_n = 0;
        step("R1 reset with load request");
        step("R1 reset held");
        rst = 0;
        quiet();

        // R12: advance before any load
        adv_n = 0;
        for (int i = 0; i < 3; i++) step("R12 advance before load");

        // R3: ce2 / ce3_n deselect the controller strobe
        addr_in = 16'h1234; ads_c_n = 0; adv_n = 1;
        ce2 = 0; step("R3 ce2 low blocks load");
        ce2 = 1; ce3_n = 1; step("R3 ce3_n high blocks load");
        // R4: ce1_n high blocks both strobes
        ce3_n = 0; ce1_n = 1; ads_c_n = 1; ads_p_n = 0;
        step("R4 processor strobe ignored with ce1_n high");
        ads_c_n = 0; step("R4 both strobes with ce1_n high");
        quiet();

        // Sweep: order x start x upper bits, with a hold and a wrap
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int u = 0; u < 3; u++) begin
                    quiet();
                    mode = m[0];
                    addr_in = {14'(u * 16'h1555 + 3), s[1:0]};
                    case ((s + u) % 3)
                        0: ads_p_n = 0;
                        1: ads_c_n = 0;
                        default: begin ads_p_n = 0; ads_c_n = 0; end
                    endcase
                    step("R2 R5 burst load");
                    quiet();
                    addr_in = 16'hFFFF;
                    adv_n = 0;
                    step(m ? "R7 interleaved beat 1" : "R8 linear beat 1");
                    adv_n = 1;
                    step("R9 hold mid burst");
                    adv_n = 0;
                    step(m ? "R7 interleaved beat 2" : "R8 linear beat 2");
                    step(m ? "R7 interleaved beat 3" : "R8 linear beat 3");
                    step("R10 wrap to start, R6 upper fixed");
                    step("R10 beat 1 after wrap");
                end
            end
        end

        // R11: load wins over advance and restarts at beat 0
        quiet(); mode = 1; addr_in = 16'hA5A6; ads_c_n = 0;
        step("R2 load for priority test");
        quiet(); adv_n = 0;
        step("R7 step before reload");
        addr_in = 16'h0F03; ads_p_n = 0;
        step("R11 load beats advance");
        ads_p_n = 1;
        step("R11 first beat after reload");
        // R6: mode flip between loads keeps upper bits
        mode = 0; adv_n = 1;
        step("R6 mode change keeps upper bits");
        // R1: reset mid burst
        rst = 1; step("R1 reset mid burst");
        rst = 0; step("R12 idle after reset");

        done = 1;
        summary();
        $finish;
    end
endmodule